// File: doc/BRIEF.md
# Adaptive Delta Encoder

This block turns a stream of signed 12-bit digital samples into a delta-modulated bitstream carrying one bit per accepted sample. It holds a running estimate of the input. On each sample it reports whether the sample lies above that estimate, and it pushes the estimate toward the sample by the current step.

The step size is not fixed. It follows the pattern of the most recent output bits. A run of three equal bits means the estimate is falling behind, so the step doubles. A change of direction means the estimate is hunting around a steady input, so the step halves. The step is held between a programmable floor and ceiling.

A decoder that sees the same bits and uses the same rules can rebuild the estimate exactly. To make that possible, the estimate moves by the step that was in force before the current bit was judged. Any new step applies only from the next sample. For debug, the current estimate and step are brought out as ports.

Top module: `adm_encoder`

## Requirements
- R1: When an accepted sample is strictly greater than the current estimate, the emitted bit is 1 and the estimate rises by the current step.
- R2: When an accepted sample is less than or equal to the current estimate, the emitted bit is 0 and the estimate falls by the current step. A sample equal to the estimate yields a 0.
- R3: Each cycle with `sampleValid` high yields exactly one bit. `bitValid` is high in the following cycle, with `bitOut` holding that bit.
- R4: When the new bit matches both of the two preceding bits, the step doubles. The doubled step is limited to STEP_MAX (default 256).
- R5: When the new bit differs from the preceding bit, the step halves. The halved step is limited below at STEP_MIN (default 1).
- R6: When neither R4 nor R5 applies, the step is unchanged. This includes the first two bits after reset, while the bit history is not yet full.
- R7: The estimate moves by the step that held before the sample was taken. A step change decided on that sample applies only to the following sample.
- R8: The estimate saturates at the input range of -2048 to 2047 instead of wrapping.
- R9: While reset is high, the estimate is 0, the step is STEP_MIN, `bitValid` is 0 and the bit history is empty.
- R10: A cycle with `sampleValid` low leaves estimate, step and history unchanged, and `bitValid` is 0 in the next cycle.
- R11: When the input rises by more per sample than the largest step, the estimate falls progressively further behind. Every bit during that ramp is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Strobe marking `sampleIn` as a new sample |
| sampleIn | input | 12 | Signed two's-complement input sample |
| bitOut | output | 1 | Direction bit: 1 means the estimate moved up |
| bitValid | output | 1 | High for one cycle after each accepted sample |
| estimateOut | output | 14 | Signed tracking estimate (debug) |
| stepOut | output | 9 | Current step size (debug) |

## Verification
On a single sample, the estimate is moved by the old step and the step is rewritten by the adaptation rule, both at the same edge. Saturation of the estimate can also land on that same edge. Stepping a ramp from a saturated floor makes the first rising bit trigger a halving while the estimate jumps by the full ceiling step. Holding the input at the top rail makes the clamp and the step doubling coincide. A behavioural reference in the bench rebuilds estimate and step every clock, and a deviation of even one unit is judged against it with the step rule in force at that edge.

// File: rtl/adm_pkg.sv
package adm_pkg;

  // Step adaptation decided by the control for the current sample
  typedef enum logic [1:0] {
    STEP_HOLD   = 2'd0,
    STEP_GROW   = 2'd1,
    STEP_SHRINK = 2'd2
  } stepAct_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;    // accept the sample this cycle
    logic     dirUp;   // move the estimate upward
    stepAct_e stepAct; // how the step changes after this sample
  } admCtrl_t;

endpackage

// File: rtl/adm_step_adapt.sv
module adm_step_adapt
  import adm_pkg::*;
#(
  parameter int STEP_W   = 9,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 256
) (
  input  logic [STEP_W-1:0] stepCur,
  input  stepAct_e          stepAct,
  output logic [STEP_W-1:0] stepNext
);

  localparam logic [STEP_W:0]   MAX_WIDE = (STEP_W+1)'(STEP_MAX);
  localparam logic [STEP_W-1:0] MAX_N    = STEP_W'(STEP_MAX);
  localparam logic [STEP_W-1:0] MIN_N    = STEP_W'(STEP_MIN);

  logic [STEP_W:0]   doubled;
  logic [STEP_W-1:0] halved;

  assign doubled = {stepCur, 1'b0};
  assign halved  = stepCur >> 1;

  always_comb begin
    unique case (stepAct)
      STEP_GROW:   stepNext = (doubled > MAX_WIDE) ? MAX_N : doubled[STEP_W-1:0];
      STEP_SHRINK: stepNext = (halved < MIN_N) ? MIN_N : halved;
      default:     stepNext = stepCur;
    endcase
  end

endmodule

// File: rtl/adm_datapath.sv
module adm_datapath
  import adm_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int EST_W    = 14,
  parameter int STEP_W   = 9,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  admCtrl_t                   ctrl,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       cmpGreater,
  output logic signed [EST_W-1:0]    estimate,
  output logic        [STEP_W-1:0]   step
);

  // One guard bit so that estimate +/- step never overflows before clamping
  localparam int SUM_W    = EST_W + 1;
  localparam int LIM_HI_I = (1 << (SAMPLE_W - 1)) - 1;
  localparam int LIM_LO_I = -(1 << (SAMPLE_W - 1));
  localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'(LIM_HI_I);
  localparam logic signed [SUM_W-1:0] LIM_LO = SUM_W'(LIM_LO_I);

  logic signed [SUM_W-1:0] sampleWide;
  logic signed [SUM_W-1:0] estWide;
  logic signed [SUM_W-1:0] stepWide;
  logic signed [SUM_W-1:0] movedWide;
  logic signed [SUM_W-1:0] clampedWide;
  logic        [STEP_W-1:0] stepNext;

  assign sampleWide = SUM_W'(sampleIn);
  assign estWide    = SUM_W'(estimate);
  assign stepWide   = $signed({{(SUM_W-STEP_W){1'b0}}, step});

  // Direction decision against the estimate held before this sample
  assign cmpGreater = sampleWide > estWide;

  always_comb begin
    movedWide = ctrl.dirUp ? (estWide + stepWide) : (estWide - stepWide);
    if (movedWide > LIM_HI) begin
      clampedWide = LIM_HI;
    end else if (movedWide < LIM_LO) begin
      clampedWide = LIM_LO;
    end else begin
      clampedWide = movedWide;
    end
  end

  adm_step_adapt #(
    .STEP_W  (STEP_W),
    .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX)
  ) stepAdapt_i (
    .stepCur (step),
    .stepAct (ctrl.stepAct),
    .stepNext(stepNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      estimate <= '0;
      step     <= STEP_W'(STEP_MIN);
    end else if (ctrl.load) begin
      estimate <= clampedWide[EST_W-1:0];
      step     <= stepNext;
    end
  end

endmodule

// File: rtl/adm_control.sv
module adm_control
  import adm_pkg::*;
#(
  parameter int RUN_LEN = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sampleValid,
  input  logic     cmpGreater,
  output admCtrl_t ctrl,
  output logic     bitOut,
  output logic     bitValid
);

  // Bits remembered besides the current one; bit 0 is the most recent
  localparam int HIST_W = RUN_LEN - 1;
  localparam int CNT_W  = $clog2(RUN_LEN);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(HIST_W);

  logic [HIST_W-1:0] histBits;
  logic [CNT_W-1:0]  fillCnt;
  logic              runMatch;
  logic              altMatch;

  always_comb begin
    runMatch = (fillCnt == FULL_CNT);
    for (int i = 0; i < HIST_W; i++) begin
      if (histBits[i] != cmpGreater) runMatch = 1'b0;
    end
    altMatch = (fillCnt != '0) && (histBits[0] != cmpGreater);
  end

  always_comb begin
    ctrl.load  = sampleValid;
    ctrl.dirUp = cmpGreater;
    if (!sampleValid) begin
      ctrl.stepAct = STEP_HOLD;
    end else if (runMatch) begin
      ctrl.stepAct = STEP_GROW;
    end else if (altMatch) begin
      ctrl.stepAct = STEP_SHRINK;
    end else begin
      ctrl.stepAct = STEP_HOLD;
    end
  end

  generate
    if (HIST_W == 1) begin : g_histSingle
      always_ff @(posedge clk) begin
        if (rst) begin
          histBits <= '0;
        end else if (sampleValid) begin
          histBits <= cmpGreater;
        end
      end
    end else begin : g_histShift
      always_ff @(posedge clk) begin
        if (rst) begin
          histBits <= '0;
        end else if (sampleValid) begin
          histBits <= {histBits[HIST_W-2:0], cmpGreater};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt  <= '0;
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      bitValid <= sampleValid;
      if (sampleValid) begin
        bitOut <= cmpGreater;
        if (fillCnt != FULL_CNT) fillCnt <= fillCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adm_encoder.sv
module adm_encoder
  import adm_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int EST_W    = 14,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 256,
  parameter int RUN_LEN  = 3,
  parameter int STEP_W   = $clog2(STEP_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic                       bitOut,
  output logic                       bitValid,
  output logic signed [EST_W-1:0]    estimateOut,
  output logic        [STEP_W-1:0]   stepOut
);

  admCtrl_t                ctrl;
  logic                    cmpGreater;
  logic signed [EST_W-1:0] estimate;
  logic [STEP_W-1:0]       step;

  adm_control #(
    .RUN_LEN(RUN_LEN)
  ) control_i (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .cmpGreater (cmpGreater),
    .ctrl       (ctrl),
    .bitOut     (bitOut),
    .bitValid   (bitValid)
  );

  adm_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .EST_W   (EST_W),
    .STEP_W  (STEP_W),
    .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX)
  ) datapath_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .sampleIn  (sampleIn),
    .cmpGreater(cmpGreater),
    .estimate  (estimate),
    .step      (step)
  );

  assign estimateOut = estimate;
  assign stepOut     = step;

endmodule

// File: rtl/adm_encoder_checker.sv
module adm_encoder_checker #(
  parameter int SAMPLE_W = 12,
  parameter int EST_W    = 14,
  parameter int STEP_W   = 9,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 256
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sampleValid,
  input logic signed [SAMPLE_W-1:0] sampleIn,
  input logic                       bitOut,
  input logic                       bitValid,
  input logic signed [EST_W-1:0]    estimateOut,
  input logic        [STEP_W-1:0]   stepOut
);

  localparam int LIM_HI = (1 << (SAMPLE_W - 1)) - 1;
  localparam int LIM_LO = -(1 << (SAMPLE_W - 1));

  int estNow;
  int stepNow;
  int estPrev;
  int stepPrev;
  int moveAbs;

  always_ff @(posedge clk) begin
    estPrev  <= int'(estimateOut);
    stepPrev <= int'(stepOut);
  end

  always_comb begin
    estNow  = int'(estimateOut);
    stepNow = int'(stepOut);
    moveAbs = (estNow >= estPrev) ? (estNow - estPrev) : (estPrev - estNow);
  end

  assert_bit_up_R1: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && (sampleIn > estimateOut)) |=> (bitOut && (estNow >= estPrev)));

  assert_bit_down_R2: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !(sampleIn > estimateOut)) |=> (!bitOut && (estNow <= estPrev)));

  assert_bit_latency_R3: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> bitValid);

  assert_step_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
    (stepNow <= STEP_MAX));

  assert_step_floor_R5: assert property (@(posedge clk) disable iff (rst)
    (stepNow >= STEP_MIN));

  assert_step_ratio_R6: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> ((stepNow == stepPrev) || (stepNow == 2 * stepPrev) ||
                     (2 * stepNow == stepPrev) || (stepNow == STEP_MAX) ||
                     (stepNow == STEP_MIN)));

  assert_old_step_move_R7: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> ((moveAbs == stepPrev) || (estNow == LIM_HI) || (estNow == LIM_LO)));

  assert_est_range_R8: assert property (@(posedge clk) disable iff (rst)
    ((estNow >= LIM_LO) && (estNow <= LIM_HI)));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> ((estNow == 0) && (stepNow == STEP_MIN) && !bitValid));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> (!bitValid && $stable(estimateOut) && $stable(stepOut)));

endmodule

bind adm_encoder adm_encoder_checker #(
  .SAMPLE_W(SAMPLE_W),
  .EST_W   (EST_W),
  .STEP_W  (STEP_W),
  .STEP_MIN(STEP_MIN),
  .STEP_MAX(STEP_MAX)
) checker_i (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .sampleIn   (sampleIn),
  .bitOut     (bitOut),
  .bitValid   (bitValid),
  .estimateOut(estimateOut),
  .stepOut    (stepOut)
);

// File: tb/adm_encoder_tb_top.sv
module adm_encoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_W   = 12;
  localparam int EST_W      = 14;
  localparam int STEP_MIN   = 1;
  localparam int STEP_MAX   = 256;
  localparam int STEP_W     = 9;
  localparam int LIM_HI     = 2047;
  localparam int LIM_LO     = -2048;
  localparam int WATCHDOG   = 20000;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic                       sampleValid = 1'b0;
  logic signed [SAMPLE_W-1:0] sampleIn = '0;
  logic                       bitOut;
  logic                       bitValid;
  logic signed [EST_W-1:0]    estimateOut;
  logic        [STEP_W-1:0]   stepOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adm_encoder #(
    .SAMPLE_W(SAMPLE_W),
    .EST_W   (EST_W),
    .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .sampleIn   (sampleIn),
    .bitOut     (bitOut),
    .bitValid   (bitValid),
    .estimateOut(estimateOut),
    .stepOut    (stepOut)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference state
  int mEst   = 0;
  int mStep  = STEP_MIN;
  int mBit   = 0;
  int mValid = 0;
  int hist[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mEst   = 0;
    mStep  = STEP_MIN;
    mBit   = 0;
    mValid = 0;
    hist.delete();
  endtask

  // One clock: drive at a falling edge, compare at the next falling edge
  task automatic drive(input bit v, input int s);
    string estTag   = "R7";
    string stepTag  = "R6";
    string bitTag   = "R2";
    string validTag = "R3";
    int    nextEst;
    int    b;
    bit    grow;
    bit    shrink;
    sampleValid = v;
    sampleIn    = SAMPLE_W'(s);
    if (v) begin
      b       = (s > mEst) ? 1 : 0;
      bitTag  = b ? "R1" : "R2";
      nextEst = b ? (mEst + mStep) : (mEst - mStep);
      if (nextEst > LIM_HI) begin
        nextEst = LIM_HI;
        estTag  = "R8";
      end else if (nextEst < LIM_LO) begin
        nextEst = LIM_LO;
        estTag  = "R8";
      end
      grow   = (hist.size() >= 2) && (hist[$] == b) && (hist[$-1] == b);
      shrink = (hist.size() >= 1) && (hist[$] != b);
      if (grow) begin
        stepTag = "R4";
        mStep   = (mStep * 2 > STEP_MAX) ? STEP_MAX : mStep * 2;
      end else if (shrink) begin
        stepTag = "R5";
        mStep   = (mStep / 2 < STEP_MIN) ? STEP_MIN : mStep / 2;
      end
      hist.push_back(b);
      if (hist.size() > 2) void'(hist.pop_front());
      mEst   = nextEst;
      mBit   = b;
      mValid = 1;
    end else begin
      mValid   = 0;
      validTag = "R10";
      estTag   = "R10";
      stepTag  = "R10";
    end
    @(negedge clk);
    check(int'(bitValid) == mValid, validTag, "bitValid", int'(bitValid), mValid);
    if (mValid != 0) check(int'(bitOut) == mBit, bitTag, "bitOut", int'(bitOut), mBit);
    check(int'(estimateOut) == mEst, estTag, "estimate", int'(estimateOut), mEst);
    check(int'(stepOut) == mStep, stepTag, "step", int'(stepOut), mStep);
  endtask

  task automatic doReset();
    rst         = 1'b1;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    modelReset();
    check(int'(estimateOut) == 0, "R9", "estimate in reset", int'(estimateOut), 0);
    check(int'(stepOut) == STEP_MIN, "R9", "step in reset", int'(stepOut), STEP_MIN);
    check(bitValid == 1'b0, "R9", "bitValid in reset", int'(bitValid), 0);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL R3 watchdog expired actual %0d expected %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ones;
    int lagFirst;
    int lagLast;
    int s;
    @(negedge clk);
    doReset();

    // R10: idle cycles change nothing
    for (int i = 0; i < 4; i++) drive(1'b0, 900);

    // R2: a sample equal to the estimate gives 0
    drive(1'b1, 0);
    check(bitOut == 1'b0, "R2", "equal sample bit", int'(bitOut), 0);
    check(int'(estimateOut) == -1, "R2", "equal sample estimate", int'(estimateOut), -1);

    // R5/R6: steady input, alternation keeps step at the floor
    for (int i = 0; i < 10; i++) drive(1'b1, 0);
    check(int'(stepOut) == STEP_MIN, "R5", "step floor on alternation", int'(stepOut), STEP_MIN);

    // Slow rise
    for (int i = 0; i < 30; i++) drive(1'b1, 40 * i);

    // R8/R4: drive the floor until saturated with the step at its ceiling
    for (int i = 0; i < 30; i++) drive(1'b1, LIM_LO);
    check(int'(estimateOut) == LIM_LO, "R8", "low saturation", int'(estimateOut), LIM_LO);
    check(int'(stepOut) == STEP_MAX, "R4", "step ceiling", int'(stepOut), STEP_MAX);

    // R11 and R7: ramp steeper than the largest step
    ones     = 0;
    lagFirst = 0;
    lagLast  = 0;
    for (int k = 1; k <= 12; k++) begin
      s = LIM_LO + 300 * k;
      drive(1'b1, s);
      if (bitOut) ones++;
      if (k == 1) begin
        lagFirst = s - int'(estimateOut);
        // first up bit after zeros: moved by old ceiling step, step halved
        check(int'(estimateOut) == LIM_LO + STEP_MAX, "R7", "old step used",
              int'(estimateOut), LIM_LO + STEP_MAX);
      end
      lagLast = s - int'(estimateOut);
    end
    check(ones == 12, "R11", "ones during overload", ones, 12);
    check(lagLast > lagFirst, "R11", "lag grows in overload", lagLast, lagFirst + 1);

    // R8: hold at the top rail
    for (int i = 0; i < 20; i++) drive(1'b1, LIM_HI);
    check(int'(estimateOut) <= LIM_HI, "R8", "high bound", int'(estimateOut), LIM_HI);

    // Mixed random traffic with idle gaps (R10 and R3)
    for (int i = 0; i < 300; i++) begin
      drive($urandom_range(0, 3) != 0, int'($urandom_range(0, 4095)) - 2048);
    end

    // R9: reset in mid-stream clears history
    for (int i = 0; i < 5; i++) drive(1'b1, 1500);
    doReset();
    drive(1'b1, 1000);
    drive(1'b1, 1000);
    check(int'(stepOut) == STEP_MIN, "R9", "history cleared, no early growth",
          int'(stepOut), STEP_MIN);
    drive(1'b1, 1000);
    check(int'(stepOut) == 2, "R4", "growth on third equal bit", int'(stepOut), 2);
    drive(1'b0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule